// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises characters onto a single asynchronous line. A holding register sits in front of a shift register. Software-style logic writes a character into the holding register with a one-cycle write strobe. When the shift register is free and the launch conditions hold, the character moves into the shift register automatically and goes out as one frame. The holding register is then free for the next character.

A frame is launched only while the end-of-frame window is open. That window stays open the whole time the line is idle. During a frame it opens only in the final clock of the last stop bit. Once a frame is under way, the enable, holding-register and clear-to-send conditions are not looked at again until that frame finishes. The next character can therefore be written while the current one is still shifting, and the two frames follow each other with no idle gap. Character length, parity, stop-bit count and the bit-rate divisor are captured when a frame is launched.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A frame is launched only in a cycle where frameEnd is 1, txEnable is 1, bufEmpty is 0, and either ctsSel is 0 or ctsN is 0. When launched, txEmpty is 0 and the start bit is on txLine from the next cycle.
- R2: A frame has the following parts, in this order:
  - a low start bit;
  - the data bits, least significant first; charLen 2'b00 sends 7 bits, 2'b01 sends 8, 2'b10 sends 9, and 2'b11 sends 8;
  - when parityEn is 1, a parity bit: the XOR of the sent data bits if parityOdd is 0, or its inverse if parityOdd is 1;
  - one high stop bit, or two when twoStop is 1.
- R3: A write sets bufEmpty to 0 in the next cycle, and a transfer into the shift register sets it to 1. A write in the same cycle as a transfer leaves bufEmpty at 0 and keeps the newly written character for the following frame.
- R4: If the launch condition holds in the last cycle of a frame, the next start bit begins in the very next cycle, and txEmpty stays 0 across the boundary.
- R5: While txEmpty is 1, txLine is high.
- R6: During a frame, changes to txEnable, ctsN, ctsSel, charLen, parityEn, parityOdd, twoStop and divN do not alter or cut short that frame.
- R7: txEmpty becomes 1 in the cycle after a frameEnd cycle in which no frame is launched. It becomes 0 in the cycle after a launch.
- R8: txIrq is a one-cycle pulse in exactly those cycles in which bufEmpty has just changed from 0 to 1.
- R9: frameEnd is 1 while idle and in the final clock cycle of the last stop bit, and 0 in every other cycle of a frame.
- R10: After a synchronous reset, txLine, bufEmpty and txEmpty are 1 and txIrq is 0.
- R11: Every bit of a frame lasts (divN + 1) × 16 clock cycles, using the divN value captured at launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-rate source |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Character to write |
| charLen | input | 2 | Character length code |
| parityEn | input | 1 | Append a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| txEnable | input | 1 | Transmit enable |
| ctsSel | input | 1 | 1 = gate launch on ctsN |
| ctsN | input | 1 | Clear-to-send, active low |
| divN | input | 8 | Bit-rate divisor n |
| txLine | output | 1 | Serial output, idle high |
| bufEmpty | output | 1 | Holding register is free |
| txEmpty | output | 1 | No frame in progress |
| frameEnd | output | 1 | End-of-frame window |
| txIrq | output | 1 | One-cycle pulse when the holding register frees |

## Verification
A bit counter or captured frame length that is off by one shows up at the ports in two ways: frameEnd is one bit period early or late, and txLine carries a wrong level where a stop or parity bit should be. Both appear within the frame they affect. A wrong baud-count limit shifts the very first data-bit edge, which is visible within the first bit period after launch. A stale holding-register flag shows up in the cycle after the offending write or transfer, either as a missing or extra txIrq or as a launch that should not happen. Because the outputs are compared cycle by cycle, each of these faults is caught at the first cycle it distorts.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;   // capture holding register into shift register
    logic shift;  // advance to next bit
    logic run;    // frame in progress, bit timer counts
  } txStrobe_t;

  // Character length code to number of data bits.
  function automatic logic [3:0] decodeLen(input logic [1:0] code);
    case (code)
      2'b00:   decodeLen = 4'd7;
      2'b10:   decodeLen = 4'd9;
      default: decodeLen = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DIV_W    = 8,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         strb,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [DIV_W-1:0]  divN,
  output logic              bitTick,
  output logic              lineBit
);

  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = DIV_W + OVS_LOG2;
  localparam int POS_W   = $clog2(FRAME_W);

  logic [DATA_W-1:0]  bufReg;
  logic [FRAME_W-1:0] shReg;
  logic [FRAME_W-1:0] frameVec;
  logic [CNT_W-1:0]   baudCnt;
  logic [CNT_W-1:0]   baudLim;
  logic [3:0]         dataLen;
  logic [POS_W-1:0]   parPos;
  logic               parAcc;

  // Holding register
  always_ff @(posedge clk) begin
    if (rst)       bufReg <= '0;
    else if (wrEn) bufReg <= wrData;
  end

  // Frame assembly: start, data LSB first, optional parity, stop ones
  always_comb begin
    dataLen     = decodeLen(charLen);
    parPos      = POS_W'(dataLen) + POS_W'(1);
    parAcc      = parityOdd;
    frameVec    = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(dataLen)) begin
        frameVec[i+1] = bufReg[i];
        parAcc        = parAcc ^ bufReg[i];
      end
    end
    if (parityEn) frameVec[parPos] = parAcc;
  end

  // Shift register, refills with mark
  always_ff @(posedge clk) begin
    if (rst)             shReg <= '1;
    else if (strb.load)  shReg <= frameVec;
    else if (strb.shift) shReg <= {1'b1, shReg[FRAME_W-1:1]};
  end

  // Bit timer: (n+1) * 2^OVS_LOG2 cycles per bit, limit captured at launch
  always_ff @(posedge clk) begin
    if (rst) begin
      baudCnt <= '0;
      baudLim <= '0;
    end else if (strb.load) begin
      baudCnt <= '0;
      baudLim <= {divN, {OVS_LOG2{1'b1}}};
    end else if (strb.run) begin
      baudCnt <= bitTick ? '0 : baudCnt + CNT_W'(1);
    end
  end

  assign bitTick = strb.run & (baudCnt == baudLim);
  assign lineBit = shReg[0];

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       txEnable,
  input  logic       ctsSel,
  input  logic       ctsN,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       twoStop,
  input  logic       bitTick,
  output txStrobe_t  strb,
  output logic       busy,
  output logic       bufEmpty,
  output logic       frameEnd,
  output logic       txIrq
);

  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] lastIdxNew;
  logic             lastBit;
  logic             startOk;
  logic             load;

  assign lastBit    = (bitIdx == lastIdx);
  assign frameEnd   = ~busy | (bitTick & lastBit);
  assign startOk    = txEnable & ~bufEmpty & (~ctsSel | ~ctsN);
  assign load       = frameEnd & startOk;
  assign lastIdxNew = IDX_W'(decodeLen(charLen)) + IDX_W'(parityEn)
                    + (twoStop ? IDX_W'(2) : IDX_W'(1));

  always_comb begin
    strb       = '0;
    strb.load  = load;
    strb.shift = busy & bitTick & ~lastBit;
    strb.run   = busy;
  end

  // Frame sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitIdx  <= '0;
      lastIdx <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      bitIdx  <= '0;
      lastIdx <= lastIdxNew;
    end else if (frameEnd) begin
      busy    <= 1'b0;
      bitIdx  <= '0;
    end else if (bitTick) begin
      bitIdx  <= bitIdx + IDX_W'(1);
    end
  end

  // Holding register flag and its interrupt pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      bufEmpty <= 1'b1;
      txIrq    <= 1'b0;
    end else begin
      txIrq <= load & ~wrEn;
      if (wrEn)      bufEmpty <= 1'b0;
      else if (load) bufEmpty <= 1'b1;
    end
  end

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
  import dbuf_uart_tx_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int DIV_W    = 8,
  parameter int OVS_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              txEnable,
  input  logic              ctsSel,
  input  logic              ctsN,
  input  logic [DIV_W-1:0]  divN,
  output logic              txLine,
  output logic              bufEmpty,
  output logic              txEmpty,
  output logic              frameEnd,
  output logic              txIrq
);

  txStrobe_t strb;
  logic      bitTick;
  logic      lineBit;
  logic      busy;

  uart_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .txEnable (txEnable),
    .ctsSel   (ctsSel),
    .ctsN     (ctsN),
    .charLen  (charLen),
    .parityEn (parityEn),
    .twoStop  (twoStop),
    .bitTick  (bitTick),
    .strb     (strb),
    .busy     (busy),
    .bufEmpty (bufEmpty),
    .frameEnd (frameEnd),
    .txIrq    (txIrq)
  );

  uart_tx_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W), .OVS_LOG2(OVS_LOG2)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .charLen   (charLen),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .divN      (divN),
    .bitTick   (bitTick),
    .lineBit   (lineBit)
  );

  assign txLine  = busy ? lineBit : 1'b1;
  assign txEmpty = ~busy;

endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic wrEn,
  input logic txLine,
  input logic bufEmpty,
  input logic txEmpty,
  input logic frameEnd,
  input logic txIrq
);

  // R5: mark level whenever no frame is in progress
  a_r5_idle_mark: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> txLine);

  // R2: the first cycle of a frame carries the low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    $fell(txEmpty) |-> !txLine);

  // R3: a write always leaves the holding register full
  a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !bufEmpty);

  // R6: a frame cannot stop outside its end window
  a_r6_no_cut: assert property (@(posedge clk) disable iff (rst)
    (!txEmpty && !frameEnd) |=> !txEmpty);

  // R7: empty flag rises only after an end-of-frame cycle
  a_r7_empty_after_end: assert property (@(posedge clk) disable iff (rst)
    $rose(txEmpty) |-> $past(frameEnd));

  // R8: interrupt pulse aligns with each release of the holding register
  a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(bufEmpty) |-> txIrq);
  a_r8_irq_only_rise: assert property (@(posedge clk) disable iff (rst)
    txIrq |-> $rose(bufEmpty));

  // R9: the window is open whenever idle
  a_r9_idle_window: assert property (@(posedge clk) disable iff (rst)
    txEmpty |-> frameEnd);

endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .txLine   (txLine),
  .bufEmpty (bufEmpty),
  .txEmpty  (txEmpty),
  .frameEnd (frameEnd),
  .txIrq    (txIrq)
);

// File: tb/dbuf_uart_tx_tb.sv
`timescale 1ns/1ps
module dbuf_uart_tx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic [1:0] charLen = 2'b01;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       twoStop = 1'b0;
  logic       txEnable = 1'b0;
  logic       ctsSel = 1'b0;
  logic       ctsN = 1'b1;
  logic [7:0] divN = '0;
  logic       txLine, bufEmpty, txEmpty, frameEnd, txIrq;

  int checks = 0;
  int failures = 0;
  string phase = "R10";

  always #2 clk = ~clk;

  dbuf_uart_tx u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .txEnable(txEnable), .ctsSel(ctsSel), .ctsN(ctsN), .divN(divN),
    .txLine(txLine), .bufEmpty(bufEmpty), .txEmpty(txEmpty),
    .frameEnd(frameEnd), .txIrq(txIrq)
  );

  // ---------------- behavioural reference model ----------------
  bit       mBusy = 0;
  bit       mBufEmpty = 1;
  bit       mIrq = 0;
  bit [8:0] mBuf = '0;
  bit       bitQ[$];
  int       mCyc = 0;
  int       mBitLen = 16;
  bit       fe, st, ld;

  function automatic int lenOf(input logic [1:0] c);
    return (c == 2'b00) ? 7 : (c == 2'b10) ? 9 : 8;
  endfunction

  function automatic bit modelEnd();
    return !mBusy || (bitQ.size() == 1 && mCyc == mBitLen - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mBufEmpty = 1; mIrq = 0; mBuf = '0; bitQ.delete(); mCyc = 0;
    end else begin
      fe = modelEnd();
      st = txEnable && !mBufEmpty && (!ctsSel || !ctsN);
      ld = fe && st;
      if (mBusy && !fe) begin
        mCyc++;
        if (mCyc == mBitLen) begin
          void'(bitQ.pop_front());
          mCyc = 0;
        end
      end
      if (ld) begin
        bit p;
        p = parityOdd;
        bitQ.delete();
        bitQ.push_back(1'b0);
        for (int i = 0; i < lenOf(charLen); i++) begin
          bitQ.push_back(mBuf[i]);
          p ^= mBuf[i];
        end
        if (parityEn) bitQ.push_back(p);
        bitQ.push_back(1'b1);
        if (twoStop) bitQ.push_back(1'b1);
        mBusy = 1; mCyc = 0; mBitLen = (int'(divN) + 1) * 16;
      end else if (fe) begin
        mBusy = 0;
        bitQ.delete();
      end
      mIrq = ld && !wrEn;
      if (wrEn) begin
        mBufEmpty = 0;
        mBuf = wrData;
      end else if (ld) begin
        mBufEmpty = 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      if (failures < 30)
        $display("FAIL %s (%s) %s at %0t: actual=%b expected=%b", req, phase, what, $time, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2", "txLine", txLine, mBusy ? bitQ[0] : 1'b1);
      check("R3", "bufEmpty", bufEmpty, mBufEmpty);
      check("R7", "txEmpty", txEmpty, !mBusy);
      check("R9", "frameEnd", frameEnd, modelEnd());
      check("R8", "txIrq", txIrq, mIrq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic doWrite(input logic [8:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (!(txEmpty === 1'b1 && bufEmpty === 1'b1)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "txLine", txLine, 1'b1);
    check("R10", "bufEmpty", bufEmpty, 1'b1);
    check("R10", "txEmpty", txEmpty, 1'b1);
    check("R10", "txIrq", txIrq, 1'b0);

    // R2: 8-bit, even parity, one stop
    phase = "R2"; txEnable = 1'b1; charLen = 2'b01; parityEn = 1'b1;
    doWrite(9'h0A5);
    waitIdle();
    phase = "R2"; parityOdd = 1'b1;
    doWrite(9'h03C);
    waitIdle();

    // R4: 9-bit, no parity, two stop, back-to-back
    phase = "R4"; charLen = 2'b10; parityEn = 1'b0; twoStop = 1'b1;
    doWrite(9'h1C3);
    while (bufEmpty !== 1'b1) @(negedge clk);
    doWrite(9'h05A);
    bad = 0;
    while (bufEmpty !== 1'b1) begin
      @(negedge clk);
      if (txEmpty !== 1'b0) bad++;
    end
    check("R4", "gap between frames", bad == 0, 1'b1);
    waitIdle();

    // R11: 7-bit odd parity, divN = 1, start bit width
    phase = "R11"; charLen = 2'b00; parityEn = 1'b1; parityOdd = 1'b1; twoStop = 1'b0; divN = 8'd1;
    doWrite(9'h155);
    while (txLine !== 1'b0) @(negedge clk);
    cnt = 0;
    while (txLine === 1'b0) begin cnt++; @(negedge clk); end
    check("R11", "start bit cycles==32", cnt == 32, 1'b1);
    waitIdle();

    // R1: clear-to-send blocks launch
    phase = "R1"; divN = 8'd0; charLen = 2'b11; ctsSel = 1'b1; ctsN = 1'b1;
    doWrite(9'h0F0);
    repeat (200) @(negedge clk);
    check("R1", "txEmpty held while cts high", txEmpty, 1'b1);
    check("R1", "buffer kept", bufEmpty, 1'b0);
    ctsN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "launch after cts low", txEmpty, 1'b0);

    // R6: mid-frame changes ignored
    phase = "R6";
    repeat (20) @(negedge clk);
    ctsN = 1'b1; txEnable = 1'b0; charLen = 2'b00; twoStop = 1'b1; divN = 8'd3; parityOdd = 1'b0;
    repeat (60) @(negedge clk);
    check("R6", "frame continues after disable", txEmpty, 1'b0);
    while (txEmpty !== 1'b1) @(negedge clk);
    ctsSel = 1'b0; divN = 8'd0; charLen = 2'b01;

    // R1: enable low blocks launch
    phase = "R1";
    doWrite(9'h011);
    repeat (50) @(negedge clk);
    check("R1", "no launch while disabled", txEmpty, 1'b1);

    // R3: write in the same cycle as the transfer
    phase = "R3";
    @(negedge clk);
    txEnable = 1'b1; wrEn = 1'b1; wrData = 9'h0EE;
    @(negedge clk);
    wrEn = 1'b0;
    check("R3", "bufEmpty after colliding write", bufEmpty, 1'b0);
    check("R3", "no irq on colliding write", txIrq, 1'b0);
    // overwrite while busy
    doWrite(9'h077);
    doWrite(9'h081);
    waitIdle();
    check("R5", "idle line high", txLine, 1'b1);

    phase = "end";
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule